// File: doc/BRIEF.md
# Read Completion Buffer Gating

This block holds the return data for non-posted reads that a parallel-bus requester has handed on to a serial link. It has eight request slots. Each slot records the address and command of one outstanding read and owns a 512-byte circular data store, which is 128 words of 32 bits. Completion words from the link side are written into the store of the slot they belong to. The block then decides when the parallel side may begin handing that data back to the requester, who drains it one word per cycle.

The release rule depends on the bus mode. In conventional (delayed-read) mode the store is managed in 32-byte pieces, and a slot becomes ready once a programmable number of those pieces has arrived. In split mode the pieces are 128 bytes. A split completion may only begin when the read pointer sits on a 128-byte boundary, and once it has begun it may run past 128 bytes while data remains.

A piece of the store is reused as soon as it has been fully drained, so a long read keeps streaming. In split mode a round-robin scheduler names the next ready slot to attempt. Every response to an attempt moves the scheduler on, so a retried or aborted completion does not hold up the queue.

Top module: `rcb_top`

## Requirements
- R1: While `rst` is high and on the cycle after it falls, `entry_busy`, `data_ready`, `sched_valid`, `rd_valid` and `disc_req` are all zero.
- R2: `alloc_valid` on a free slot `alloc_idx` marks it busy and stores `alloc_addr` and `alloc_cmd`, with the store emptied. An allocation aimed at a slot that is already busy is ignored and leaves its stored address unchanged.
- R3: When `split_mode` is 0, a slot that has not started draining raises `data_ready` once it holds at least 8×T words, where T is `chunk_thresh` and a T of 0 counts as 1. In this mode `sched_valid` stays 0.
- R4: When `split_mode` is 0, a slot whose final word has arrived (`cpl_last`) raises `data_ready` with any nonzero amount buffered, even below the threshold.
- R5: When `split_mode` is 1, a slot that has not started draining is ready only if its read position is a multiple of 32 words and it holds at least 32 words, or it holds its final word.
- R6: Once a slot has started draining, it stays ready while it holds any data, so a split completion can carry more than 128 bytes.
- R7: `drain_en` on slot `drain_idx` that holds data gives `rd_valid`=1 on the next cycle, with the words in the order they were written.
- R8: `cpl_ready` for slot `cpl_idx` is 0 when 128 words lie between the start of the piece holding the read position and the write position. It returns to 1 as soon as that whole piece is drained: 8 words per piece in conventional mode, 32 in split mode.
- R9: `drain_en` on a busy slot that is empty and has not received its final word gives `disc_req`=1 and `rd_valid`=0 on the next cycle. It also ends the started state of that slot.
- R10: Draining the final word of a slot whose last word has arrived frees the slot (`entry_busy` bit goes to 0).
- R11: In split mode, `sched_idx` is the first ready slot after the slot that last received a response, counting upward and wrapping. Any `sched_resp_valid` (accept=0, retry=1, abort=2) moves the scheduler past the current slot. After reset the search starts at slot 0.
- R12: A retry or abort response ends the started state of the scheduled slot. If its read position is then off a 32-word boundary, it drops `data_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| split_mode | input | 1 | 1 = split mode, 0 = conventional mode |
| chunk_thresh | input | 3 | Conventional release threshold in 32-byte pieces (0 means 1) |
| alloc_valid | input | 1 | Allocate a request slot |
| alloc_idx | input | 3 | Slot to allocate |
| alloc_addr | input | 32 | Request address stored with the slot |
| alloc_cmd | input | 4 | Request command stored with the slot |
| cpl_valid | input | 1 | Completion word present |
| cpl_idx | input | 3 | Slot the completion word belongs to |
| cpl_data | input | 32 | Completion word |
| cpl_last | input | 1 | This word is the last of the read |
| cpl_ready | output | 1 | Slot `cpl_idx` has room for a word |
| drain_en | input | 1 | Requester takes one word |
| drain_idx | input | 3 | Slot being drained |
| rd_valid | output | 1 | `rd_data` holds a drained word |
| rd_data | output | 32 | Drained word |
| disc_req | output | 1 | Drain found the slot empty mid-transfer |
| data_ready | output | 8 | Per-slot release flag |
| entry_busy | output | 8 | Per-slot allocated flag |
| sched_valid | output | 1 | A split completion candidate exists |
| sched_idx | output | 3 | Slot to attempt next |
| sched_addr | output | 32 | Address of the scheduled slot |
| sched_cmd | output | 4 | Command of the scheduled slot |
| sched_resp_valid | input | 1 | Response to the current attempt |
| sched_resp | input | 2 | 0 accept, 1 retry, 2 abort |

## Verification
The assertions take for granted three things about the inputs: `drain_en` names a busy slot, completion words go only to allocated slots that show `cpl_ready`, and a response is given only while `sched_valid` is high. Under those conditions the checker requires four things. A drained word or disconnect follows a drain request. A disconnect never comes with a word. No free slot is ready, and the scheduler names only ready slots in split mode. The bench drives inputs on the falling edge and drains only slots it has allocated. It sends completion words only within the capacity the requirements allow. It answers the scheduler only when it has checked that a candidate is offered.

// File: rtl/rcb_pkg.sv
package rcb_pkg;

    localparam int unsigned ADDR_W = 32;
    localparam int unsigned CMD_W  = 4;

    typedef enum logic [1:0] {
        RSP_ACCEPT = 2'd0,
        RSP_RETRY  = 2'd1,
        RSP_ABORT  = 2'd2
    } rsp_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [CMD_W-1:0]  cmd;
    } req_info_t;

    // words a slot must hold before conventional release; zero threshold acts as one
    function automatic int unsigned conv_need(input int unsigned th, input int unsigned seg_words);
        return ((th == 0) ? 1 : th) * seg_words;
    endfunction

endpackage

// File: rtl/rcb_entry.sv
module rcb_entry #(
    parameter int BUF_WORDS = 128,
    parameter int CONV_SEG  = 8,
    parameter int SPLIT_SEG = 32,
    parameter int TH_W      = 3,
    parameter int AW        = $clog2(BUF_WORDS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            split_mode,
    input  logic [TH_W-1:0] thresh,
    input  logic            alloc,
    input  logic            wr_en,
    input  logic            last_in,
    input  logic            rd_en,
    input  logic            restart,
    output logic            busy,
    output logic            ready,
    output logic            space_ok,
    output logic            has_data,
    output logic            starved,
    output logic [AW-1:0]   wr_addr,
    output logic [AW-1:0]   rd_addr
);
    import rcb_pkg::*;

    localparam int PTR_W = AW + 1;
    localparam logic [PTR_W-1:0] BUF_P   = PTR_W'(BUF_WORDS);
    localparam logic [PTR_W-1:0] SPLIT_P = PTR_W'(SPLIT_SEG);
    localparam logic [PTR_W-1:0] CMASK   = PTR_W'(CONV_SEG - 1);
    localparam logic [PTR_W-1:0] SMASK   = PTR_W'(SPLIT_SEG - 1);

    logic [PTR_W-1:0] wr_ptr, rd_ptr, level, used, seg_mask, need;
    logic             done, started, at_bound, split_ok, conv_ok;

    assign level    = wr_ptr - rd_ptr;
    assign seg_mask = split_mode ? SMASK : CMASK;
    assign used     = wr_ptr - (rd_ptr & ~seg_mask);
    assign space_ok = busy && !done && (used < BUF_P);
    assign has_data = (level != '0);
    assign starved  = busy && !has_data && !done;
    assign need     = PTR_W'(conv_need(int'(thresh), CONV_SEG));
    assign conv_ok  = (level >= need) || done;
    assign at_bound = ((rd_ptr & SMASK) == '0);
    assign split_ok = at_bound && ((level >= SPLIT_P) || done);
    assign ready    = busy && has_data && (started || (split_mode ? split_ok : conv_ok));
    assign wr_addr  = wr_ptr[AW-1:0];
    assign rd_addr  = rd_ptr[AW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            started <= 1'b0;
            wr_ptr  <= '0;
            rd_ptr  <= '0;
        end else if (alloc && !busy) begin
            busy    <= 1'b1;
            done    <= 1'b0;
            started <= 1'b0;
            wr_ptr  <= '0;
            rd_ptr  <= '0;
        end else begin
            if (wr_en && space_ok) begin
                wr_ptr <= wr_ptr + 1'b1;
                if (last_in) done <= 1'b1;
            end
            if (rd_en && busy) begin
                if (has_data) begin
                    rd_ptr  <= rd_ptr + 1'b1;
                    started <= 1'b1;
                    if (done && level == PTR_W'(1)) busy <= 1'b0;
                end else begin
                    started <= 1'b0;
                end
            end
            if (restart) started <= 1'b0;
        end
    end

endmodule

// File: rtl/rcb_rr_arb.sv
module rcb_rr_arb #(
    parameter int N     = 8,
    parameter int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     req,
    input  logic             advance,
    output logic             grant_valid,
    output logic [IDX_W-1:0] grant_idx
);
    logic [IDX_W-1:0] last;

    always_comb begin
        logic [IDX_W-1:0] cand;
        grant_valid = 1'b0;
        grant_idx   = last;
        for (int k = 1; k <= N; k++) begin
            cand = IDX_W'((int'(last) + k) % N);
            if (!grant_valid && req[cand]) begin
                grant_valid = 1'b1;
                grant_idx   = cand;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                         last <= IDX_W'(N - 1);
        else if (advance && grant_valid) last <= grant_idx;
    end

endmodule

// File: rtl/rcb_top.sv
module rcb_top #(
    parameter int NENT           = 8,
    parameter int BUF_BYTES      = 512,
    parameter int DATA_W         = 32,
    parameter int CONV_SEG_BYTES = 32,
    parameter int SPLIT_SEG_BYTES = 128,
    parameter int TH_W           = 3,
    parameter int IDX_W          = $clog2(NENT)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     split_mode,
    input  logic [TH_W-1:0]          chunk_thresh,
    input  logic                     alloc_valid,
    input  logic [IDX_W-1:0]         alloc_idx,
    input  logic [rcb_pkg::ADDR_W-1:0] alloc_addr,
    input  logic [rcb_pkg::CMD_W-1:0]  alloc_cmd,
    input  logic                     cpl_valid,
    input  logic [IDX_W-1:0]         cpl_idx,
    input  logic [DATA_W-1:0]        cpl_data,
    input  logic                     cpl_last,
    output logic                     cpl_ready,
    input  logic                     drain_en,
    input  logic [IDX_W-1:0]         drain_idx,
    output logic                     rd_valid,
    output logic [DATA_W-1:0]        rd_data,
    output logic                     disc_req,
    output logic [NENT-1:0]          data_ready,
    output logic [NENT-1:0]          entry_busy,
    output logic                     sched_valid,
    output logic [IDX_W-1:0]         sched_idx,
    output logic [rcb_pkg::ADDR_W-1:0] sched_addr,
    output logic [rcb_pkg::CMD_W-1:0]  sched_cmd,
    input  logic                     sched_resp_valid,
    input  logic [1:0]               sched_resp
);
    import rcb_pkg::*;

    localparam int WORD_BYTES = DATA_W / 8;
    localparam int BUF_WORDS  = BUF_BYTES / WORD_BYTES;
    localparam int CONV_SEG   = CONV_SEG_BYTES / WORD_BYTES;
    localparam int SPLIT_SEG  = SPLIT_SEG_BYTES / WORD_BYTES;
    localparam int AW         = $clog2(BUF_WORDS);

    logic [DATA_W-1:0] mem [NENT][BUF_WORDS];
    req_info_t         req_q [NENT];
    logic [AW-1:0]     wr_addr [NENT];
    logic [AW-1:0]     rd_addr [NENT];
    logic [NENT-1:0]   space_ok, has_data, starved;
    logic              resp_restart;

    assign resp_restart = sched_resp_valid && sched_valid && (rsp_e'(sched_resp) != RSP_ACCEPT);

    for (genvar i = 0; i < NENT; i++) begin : g_ent
        rcb_entry #(
            .BUF_WORDS(BUF_WORDS), .CONV_SEG(CONV_SEG),
            .SPLIT_SEG(SPLIT_SEG), .TH_W(TH_W), .AW(AW)
        ) ent_i (
            .clk(clk), .rst(rst), .split_mode(split_mode), .thresh(chunk_thresh),
            .alloc(alloc_valid && alloc_idx == IDX_W'(i)),
            .wr_en(cpl_valid && cpl_idx == IDX_W'(i)),
            .last_in(cpl_last),
            .rd_en(drain_en && drain_idx == IDX_W'(i)),
            .restart(resp_restart && sched_idx == IDX_W'(i)),
            .busy(entry_busy[i]), .ready(data_ready[i]), .space_ok(space_ok[i]),
            .has_data(has_data[i]), .starved(starved[i]),
            .wr_addr(wr_addr[i]), .rd_addr(rd_addr[i])
        );
    end

    rcb_rr_arb #(.N(NENT), .IDX_W(IDX_W)) arb_i (
        .clk(clk), .rst(rst),
        .req(split_mode ? data_ready : '0),
        .advance(sched_resp_valid),
        .grant_valid(sched_valid), .grant_idx(sched_idx)
    );

    assign cpl_ready  = space_ok[cpl_idx];
    assign sched_addr = req_q[sched_idx].addr;
    assign sched_cmd  = req_q[sched_idx].cmd;

    always_ff @(posedge clk) begin
        if (cpl_valid && cpl_ready) mem[cpl_idx][wr_addr[cpl_idx]] <= cpl_data;
        if (alloc_valid && !entry_busy[alloc_idx]) req_q[alloc_idx] <= '{addr: alloc_addr, cmd: alloc_cmd};
        rd_data <= mem[drain_idx][rd_addr[drain_idx]];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            disc_req <= 1'b0;
        end else begin
            rd_valid <= drain_en && has_data[drain_idx];
            disc_req <= drain_en && starved[drain_idx];
        end
    end

endmodule

// File: rtl/rcb_checker.sv
module rcb_checker #(
    parameter int NENT  = 8,
    parameter int IDX_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             split_mode,
    input logic             drain_en,
    input logic             rd_valid,
    input logic             disc_req,
    input logic [NENT-1:0]  data_ready,
    input logic [NENT-1:0]  entry_busy,
    input logic             sched_valid,
    input logic [IDX_W-1:0] sched_idx
);

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (entry_busy == '0 && !rd_valid && !disc_req && !sched_valid));

    assert_word_after_drain_R7: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(drain_en));

    assert_disc_no_word_R9: assert property (@(posedge clk) disable iff (rst)
        disc_req |-> ($past(drain_en) && !rd_valid));

    assert_ready_only_busy_R3: assert property (@(posedge clk) disable iff (rst)
        (data_ready & ~entry_busy) == '0);

    assert_sched_ready_R11: assert property (@(posedge clk) disable iff (rst)
        sched_valid |-> (split_mode && data_ready[sched_idx]));

endmodule

bind rcb_top rcb_checker #(.NENT(NENT), .IDX_W(IDX_W)) chk_i (
    .clk(clk), .rst(rst), .split_mode(split_mode), .drain_en(drain_en),
    .rd_valid(rd_valid), .disc_req(disc_req), .data_ready(data_ready),
    .entry_busy(entry_busy), .sched_valid(sched_valid), .sched_idx(sched_idx)
);

// File: tb/rcb_top_tb_top.sv
module rcb_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        split_mode = 1'b0;
    logic [2:0]  chunk_thresh = '0;
    logic        alloc_valid = 1'b0;
    logic [2:0]  alloc_idx = '0;
    logic [31:0] alloc_addr = '0;
    logic [3:0]  alloc_cmd = '0;
    logic        cpl_valid = 1'b0;
    logic [2:0]  cpl_idx = '0;
    logic [31:0] cpl_data = '0;
    logic        cpl_last = 1'b0;
    logic        cpl_ready;
    logic        drain_en = 1'b0;
    logic [2:0]  drain_idx = '0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        disc_req;
    logic [7:0]  data_ready, entry_busy;
    logic        sched_valid;
    logic [2:0]  sched_idx;
    logic [31:0] sched_addr;
    logic [3:0]  sched_cmd;
    logic        sched_resp_valid = 1'b0;
    logic [1:0]  sched_resp = '0;

    int n_chk = 0, n_fail = 0;
    int wcnt [8];
    int rcnt [8];
    bit finished = 0;

    always #5 clk = ~clk;

    rcb_top dut_i (
        .clk(clk), .rst(rst), .split_mode(split_mode), .chunk_thresh(chunk_thresh),
        .alloc_valid(alloc_valid), .alloc_idx(alloc_idx), .alloc_addr(alloc_addr),
        .alloc_cmd(alloc_cmd), .cpl_valid(cpl_valid), .cpl_idx(cpl_idx),
        .cpl_data(cpl_data), .cpl_last(cpl_last), .cpl_ready(cpl_ready),
        .drain_en(drain_en), .drain_idx(drain_idx), .rd_valid(rd_valid),
        .rd_data(rd_data), .disc_req(disc_req), .data_ready(data_ready),
        .entry_busy(entry_busy), .sched_valid(sched_valid), .sched_idx(sched_idx),
        .sched_addr(sched_addr), .sched_cmd(sched_cmd),
        .sched_resp_valid(sched_resp_valid), .sched_resp(sched_resp)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic split);
        @(negedge clk);
        rst = 1'b1;
        split_mode = split;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < 8; k++) begin wcnt[k] = 0; rcnt[k] = 0; end
        @(negedge clk);
    endtask

    task automatic do_alloc(input int idx, input logic [31:0] addr, input logic [3:0] cmd);
        @(negedge clk);
        alloc_valid = 1'b1; alloc_idx = 3'(idx); alloc_addr = addr; alloc_cmd = cmd;
        @(negedge clk);
        alloc_valid = 1'b0;
    endtask

    task automatic push(input int idx, input int n, input bit last);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            cpl_valid = 1'b1; cpl_idx = 3'(idx);
            cpl_data = {8'(idx), 24'(wcnt[idx])};
            cpl_last = last && (k == n - 1);
            wcnt[idx]++;
        end
        @(negedge clk);
        cpl_valid = 1'b0; cpl_last = 1'b0;
    endtask

    task automatic drain(input int idx, output logic v, output logic [31:0] d, output logic dc);
        @(negedge clk);
        drain_en = 1'b1; drain_idx = 3'(idx);
        @(negedge clk);
        v = rd_valid; d = rd_data; dc = disc_req;
        drain_en = 1'b0;
    endtask

    // drains n words and returns how many were missing or wrong
    task automatic drain_n(input int idx, input int n, output int bad);
        logic v, dc;
        logic [31:0] d;
        bad = 0;
        for (int k = 0; k < n; k++) begin
            drain(idx, v, d, dc);
            if (!v || d != {8'(idx), 24'(rcnt[idx])}) bad++;
            rcnt[idx]++;
        end
    endtask

    task automatic respond(input logic [1:0] code);
        @(negedge clk);
        sched_resp_valid = 1'b1; sched_resp = code;
        @(negedge clk);
        sched_resp_valid = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 busy in reset", entry_busy, 0);
        chk("R1 rd_valid in reset", rd_valid, 0);
        do_reset(1'b0);
        chk("R1 busy after reset", entry_busy, 0);
        chk("R1 ready after reset", data_ready, 0);
        chk("R1 sched after reset", sched_valid, 0);
        chk("R1 disc after reset", disc_req, 0);
    endtask

    task automatic t_conv;
        int bad;
        logic v, dc;
        logic [31:0] d;
        do_reset(1'b0);
        chunk_thresh = 3'd2;
        do_alloc(0, 32'h1000, 4'h6);
        chk("R2 busy after alloc", entry_busy[0], 1);
        push(0, 15, 0);
        chk("R3 below threshold 2", data_ready[0], 0);
        push(0, 1, 0);
        chk("R3 at threshold 2", data_ready[0], 1);
        chk("R3 no sched in conventional", sched_valid, 0);
        chunk_thresh = 3'd0;
        do_alloc(1, 32'h1100, 4'h6);
        push(1, 7, 0);
        chk("R3 threshold 0 below 8", data_ready[1], 0);
        push(1, 1, 0);
        chk("R3 threshold 0 at 8", data_ready[1], 1);
        chunk_thresh = 3'd3;
        do_alloc(2, 32'h1200, 4'h6);
        push(2, 3, 1);
        chk("R4 short final read ready", data_ready[2], 1);
        drain_n(2, 3, bad);
        chk("R7 data order slot 2", bad, 0);
        chk("R10 slot freed", entry_busy[2], 0);
        drain_n(0, 16, bad);
        chk("R7 data order slot 0", bad, 0);
        drain(0, v, d, dc);
        chk("R9 disconnect on empty", dc, 1);
        chk("R9 no word on empty", v, 0);
        chk("R9 slot still busy", entry_busy[0], 1);
    endtask

    task automatic t_recycle;
        int bad;
        do_reset(1'b0);
        chunk_thresh = 3'd1;
        do_alloc(3, 32'h3000, 4'h6);
        push(3, 128, 0);
        @(negedge clk);
        cpl_idx = 3'd3;
        #1 chk("R8 full store blocks", cpl_ready, 0);
        drain_n(3, 7, bad);
        @(negedge clk);
        #1 chk("R8 partial piece still blocks", cpl_ready, 0);
        drain_n(3, 1, bad);
        @(negedge clk);
        #1 chk("R8 emptied piece reused", cpl_ready, 1);
        chk("R7 recycle data", bad, 0);
    endtask

    task automatic t_split;
        int bad;
        do_reset(1'b1);
        do_alloc(4, 32'h4000, 4'hE);
        push(4, 31, 0);
        chk("R5 below 32 words", data_ready[4], 0);
        push(4, 1, 0);
        chk("R5 at boundary with 32", data_ready[4], 1);
        chk("R11 sched offered", sched_valid, 1);
        chk("R11 sched slot", sched_idx, 4);
        push(4, 20, 0);
        drain_n(4, 33, bad);
        chk("R6 stream data", bad, 0);
        chk("R6 ready past 128 bytes", data_ready[4], 1);
        drain_n(4, 7, bad);
        respond(2'd1);
        chk("R12 retry off boundary drops ready", data_ready[4], 0);
        chk("R12 no candidate", sched_valid, 0);
    endtask

    task automatic t_rr;
        do_reset(1'b1);
        do_alloc(1, 32'h100, 4'h1);
        do_alloc(3, 32'h300, 4'h3);
        do_alloc(6, 32'h600, 4'h6);
        do_alloc(3, 32'hBAD, 4'hF);
        push(1, 32, 0);
        push(3, 32, 0);
        push(6, 32, 0);
        chk("R11 first pick", sched_idx, 1);
        chk("R2 addr slot 1", sched_addr, 32'h100);
        respond(2'd1);
        chk("R11 retry moves on", sched_idx, 3);
        chk("R2 busy alloc ignored", sched_addr, 32'h300);
        chk("R2 cmd kept", sched_cmd, 4'h3);
        respond(2'd2);
        chk("R11 abort moves on", sched_idx, 6);
        respond(2'd0);
        chk("R11 wrap after accept", sched_idx, 1);
    endtask

    initial begin
        t_reset();
        t_conv();
        t_recycle();
        t_split();
        t_rr();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule